// File: doc/BRIEF.md
# Handheld Memory Map Decoder

This block sits on the 16-bit CPU bus of an 8-bit handheld. For every load or store it names the single target that serves the access: fixed ROM, switchable ROM, video RAM, external RAM, fixed work RAM, banked work RAM, sprite attribute memory, I/O registers, high RAM or the interrupt-enable register. It gives a one-hot select and the offset of the access inside that target. Stores into the ROM window never address storage; they go out as commands to the bank controller.

The block holds the work-RAM bank select register, so the offset it hands to the banked work RAM already carries the bank number. A video-mode input blocks sprite memory while the display engine owns it. A blocked or unusable access selects nothing, a blocked read is given an all-ones fill value, and a one-cycle error flag follows each such access.

Decode is purely combinational. Only the bank register and the error flag are clocked.

Top module: `hh_map_decoder`

## Requirements
- R1: Reads with address bits [15:12] in 0–3 select fixed ROM (tgtSel bit 0), in 4–7 switchable ROM (bit 1), both with offset addr[13:0]; 0x8000–0x9FFF selects video RAM (bit 2) with offset addr[12:0].
- R2: 0xA000–0xBFFF selects external RAM (bit 3) with offset addr[12:0]; 0xC000–0xCFFF and its mirror 0xE000–0xEFFF select fixed work RAM (bit 4) with offset addr[11:0].
- R3: 0xD000–0xDFFF and the mirror 0xF000–0xFDFF select banked work RAM (bit 5) with offset {wramBank, addr[11:0]}.
- R4: A bankLoad pulse stores bankVal into the bank register, with 0 replaced by 1. The new value appears on wramBank from the next cycle, and reset leaves it at 1.
- R5: 0xFE00–0xFE9F selects sprite memory (bit 6) with offset addr[7:0] only while vidMode is 0 or 1. With vidMode 2 or 3 the access selects nothing and is blocked.
- R6: 0xFEA0–0xFEFF is always blocked and selects nothing.
- R7: 0xFF00–0xFF7F selects I/O (bit 7) with offset addr[6:0]. 0xFF80–0xFFFE selects high RAM (bit 8) with offset addr[6:0]. 0xFFFF selects the interrupt-enable register (bit 9) with offset 0.
- R8: A store to 0x0000–0x7FFF raises mbcWr, selects nothing, and gives offset addr[14:0]. Loads there leave mbcWr low.
- R9: rdFill is 0xFF for a blocked read and 0x00 otherwise; a blocked access has offset 0.
- R10: errPulse is high in the cycle after a blocked access and low after any other cycle.
- R11: With busRd and busWr both low, tgtSel is zero, mbcWr is low, and nothing is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| busAddr | input | 16 | CPU address |
| busRd | input | 1 | Load strobe |
| busWr | input | 1 | Store strobe (takes precedence) |
| vidMode | input | 2 | Current display mode |
| bankLoad | input | 1 | Write of the work-RAM bank select |
| bankVal | input | BANK_W | Low bits of the written bank value |
| tgtSel | output | 10 | One-hot target select |
| tgtOffset | output | OFF_W | Offset within the target |
| mbcWr | output | 1 | Bank-controller command strobe |
| rdFill | output | 8 | 0xFF on a blocked read |
| wramBank | output | BANK_W | Current work-RAM bank |
| errPulse | output | 1 | Blocked access in the previous cycle |

## Verification
tgtSel, tgtOffset, mbcWr and rdFill depend only on the inputs in the same cycle. The bench drives each access on a falling edge and checks these outputs a moment later, using the bank value its model holds at that time. wramBank and errPulse change one edge later. They are checked at the next falling edge, before new stimulus is applied, against the model state left by the previous access.

// File: rtl/hh_map_pkg.sv
package hh_map_pkg;
  localparam int NTGT = 10;

  typedef enum logic [3:0] {
    T_ROM0, T_ROMX, T_VRAM, T_XRAM, T_WRAM0,
    T_WRAMX, T_OAM, T_IO, T_HRAM, T_IE
  } tgt_e;

  typedef enum logic [2:0] {
    OK_NONE, OK_CMD, OK_W14, OK_W13, OK_W12, OK_BANK, OK_W8, OK_W7
  } offKind_e;

  typedef struct packed {
    logic     hit;
    tgt_e     tgt;
    logic     mbcCmd;
    logic     blocked;
    logic     blockedRd;
    offKind_e offKind;
  } mapCtl_t;
endpackage

// File: rtl/hh_map_ctrl.sv
module hh_map_ctrl
  import hh_map_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] busAddr,
  input  logic        busRd,
  input  logic        busWr,
  input  logic [1:0]  vidMode,
  output mapCtl_t     ctl
);
  logic       access;
  logic [3:0] hi;

  assign access = busRd | busWr;
  assign hi     = busAddr[15:12];

  always_comb begin
    ctl         = '0;
    ctl.tgt     = T_ROM0;
    ctl.offKind = OK_NONE;
    if (access) begin
      if (!hi[3]) begin
        if (busWr) begin
          ctl.mbcCmd  = 1'b1;
          ctl.offKind = OK_CMD;
        end else begin
          ctl.hit     = 1'b1;
          ctl.tgt     = hi[2] ? T_ROMX : T_ROM0;
          ctl.offKind = OK_W14;
        end
      end else begin
        unique case (hi)
          4'h8, 4'h9: begin ctl.hit = 1'b1; ctl.tgt = T_VRAM;  ctl.offKind = OK_W13; end
          4'hA, 4'hB: begin ctl.hit = 1'b1; ctl.tgt = T_XRAM;  ctl.offKind = OK_W13; end
          4'hC, 4'hE: begin ctl.hit = 1'b1; ctl.tgt = T_WRAM0; ctl.offKind = OK_W12; end
          4'hD:       begin ctl.hit = 1'b1; ctl.tgt = T_WRAMX; ctl.offKind = OK_BANK; end
          default: begin
            if (busAddr[11:9] != 3'b111) begin
              ctl.hit = 1'b1; ctl.tgt = T_WRAMX; ctl.offKind = OK_BANK;
            end else if (!busAddr[8]) begin
              if (busAddr[7:0] < 8'hA0 && vidMode < 2'd2) begin
                ctl.hit = 1'b1; ctl.tgt = T_OAM; ctl.offKind = OK_W8;
              end else begin
                ctl.blocked = 1'b1;
              end
            end else if (!busAddr[7]) begin
              ctl.hit = 1'b1; ctl.tgt = T_IO; ctl.offKind = OK_W7;
            end else if (busAddr[6:0] == 7'h7F) begin
              ctl.hit = 1'b1; ctl.tgt = T_IE;
            end else begin
              ctl.hit = 1'b1; ctl.tgt = T_HRAM; ctl.offKind = OK_W7;
            end
          end
        endcase
      end
      ctl.blockedRd = ctl.blocked & ~busWr;
    end
  end

  // R5
  oam_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.hit && ctl.tgt == T_OAM) |-> (vidMode < 2'd2 && busAddr[15:8] == 8'hFE));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd || busWr) |-> !(ctl.hit || ctl.mbcCmd || ctl.blocked));
endmodule

// File: rtl/hh_map_dp.sv
module hh_map_dp
  import hh_map_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int FILL_W = 8,
  parameter int OFF_W  = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  mapCtl_t           ctl,
  input  logic [15:0]       busAddr,
  input  logic              bankLoad,
  input  logic [BANK_W-1:0] bankVal,
  output logic [NTGT-1:0]   tgtSel,
  output logic [OFF_W-1:0]  tgtOffset,
  output logic              mbcWr,
  output logic [FILL_W-1:0] rdFill,
  output logic [BANK_W-1:0] wramBank,
  output logic              errPulse
);
  logic [BANK_W-1:0] bankQ;
  logic              errQ;

  for (genvar i = 0; i < NTGT; i++) begin : g_sel
    assign tgtSel[i] = ctl.hit && (ctl.tgt == tgt_e'(i));
  end

  always_comb begin
    unique case (ctl.offKind)
      OK_CMD:  tgtOffset = OFF_W'(busAddr[14:0]);
      OK_W14:  tgtOffset = OFF_W'(busAddr[13:0]);
      OK_W13:  tgtOffset = OFF_W'(busAddr[12:0]);
      OK_W12:  tgtOffset = OFF_W'(busAddr[11:0]);
      OK_BANK: tgtOffset = OFF_W'({bankQ, busAddr[11:0]});
      OK_W8:   tgtOffset = OFF_W'(busAddr[7:0]);
      OK_W7:   tgtOffset = OFF_W'(busAddr[6:0]);
      default: tgtOffset = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ <= BANK_W'(1);
      errQ  <= 1'b0;
    end else begin
      errQ <= ctl.blocked;
      if (bankLoad) bankQ <= (bankVal == '0) ? BANK_W'(1) : bankVal;
    end
  end

  assign mbcWr    = ctl.mbcCmd;
  assign rdFill   = ctl.blockedRd ? '1 : '0;
  assign wramBank = bankQ;
  assign errPulse = errQ;

  // R4
  bank_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    wramBank != '0);
  // R4
  bank_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bankLoad && bankVal != '0) |=> wramBank == $past(bankVal));
  // R10
  err_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.blocked |=> errPulse);
  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.blocked |=> !errPulse);
  // R8
  mbc_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    mbcWr |-> tgtSel == '0);
  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tgtSel));
endmodule

// File: rtl/hh_map_decoder.sv
module hh_map_decoder
  import hh_map_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int FILL_W = 8,
  localparam int OFF_W = (12 + BANK_W > 15) ? 12 + BANK_W : 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [1:0]        vidMode,
  input  logic              bankLoad,
  input  logic [BANK_W-1:0] bankVal,
  output logic [NTGT-1:0]   tgtSel,
  output logic [OFF_W-1:0]  tgtOffset,
  output logic              mbcWr,
  output logic [FILL_W-1:0] rdFill,
  output logic [BANK_W-1:0] wramBank,
  output logic              errPulse
);
  mapCtl_t ctl;

  hh_map_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd),
    .busWr(busWr), .vidMode(vidMode), .ctl(ctl)
  );

  hh_map_dp #(.BANK_W(BANK_W), .FILL_W(FILL_W), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busAddr(busAddr),
    .bankLoad(bankLoad), .bankVal(bankVal), .tgtSel(tgtSel),
    .tgtOffset(tgtOffset), .mbcWr(mbcWr), .rdFill(rdFill),
    .wramBank(wramBank), .errPulse(errPulse)
  );
endmodule

// File: tb/hh_map_decoder_bench.sv
module hh_map_decoder_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busRd = 1'b0, busWr = 1'b0, bankLoad = 1'b0;
  logic [1:0]  vidMode = '0;
  logic [2:0]  bankVal = '0;
  logic [9:0]  tgtSel;
  logic [14:0] tgtOffset;
  logic        mbcWr, errPulse;
  logic [7:0]  rdFill;
  logic [2:0]  wramBank;

  int checks = 0, errors = 0;
  logic [2:0] expBank = 3'd1;
  logic       expErr = 1'b0;
  bit         done = 1'b0;

  logic [9:0]  eSel;
  logic [14:0] eOff;
  logic        eMbc, eBlk;
  logic [7:0]  eFill;
  string       eReq;

  always #(CLK_P/2) clk = ~clk;

  hh_map_decoder u_hh_map_decoder (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .vidMode(vidMode), .bankLoad(bankLoad), .bankVal(bankVal),
    .tgtSel(tgtSel), .tgtOffset(tgtOffset), .mbcWr(mbcWr), .rdFill(rdFill),
    .wramBank(wramBank), .errPulse(errPulse)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h addr=%04h", req, what, act, exp, busAddr);
    end
  endtask

  function automatic void model(logic [15:0] a, logic rd, logic wr, logic [1:0] md, logic [2:0] bk);
    eSel = '0; eOff = '0; eMbc = 0; eBlk = 0; eFill = 8'h00; eReq = "R11";
    if (!(rd || wr)) return;
    if (a < 16'h8000) begin
      eReq = wr ? "R8" : "R1";
      if (wr) begin eMbc = 1; eOff = a[14:0]; end
      else begin eSel[a[14] ? 1 : 0] = 1'b1; eOff = {1'b0, a[13:0]}; end
    end else if (a < 16'hA000) begin eReq = "R1"; eSel[2] = 1; eOff = 15'(a[12:0]); end
    else if (a < 16'hC000) begin eReq = "R2"; eSel[3] = 1; eOff = 15'(a[12:0]); end
    else if (a[15:12] == 4'hC || a[15:12] == 4'hE) begin eReq = "R2"; eSel[4] = 1; eOff = 15'(a[11:0]); end
    else if (a < 16'hFE00) begin eReq = "R3"; eSel[5] = 1; eOff = {bk, a[11:0]}; end
    else if (a < 16'hFEA0) begin
      eReq = "R5";
      if (md < 2) begin eSel[6] = 1; eOff = 15'(a[7:0]); end else eBlk = 1;
    end else if (a < 16'hFF00) begin eReq = "R6"; eBlk = 1; end
    else if (a < 16'hFF80) begin eReq = "R7"; eSel[7] = 1; eOff = 15'(a[6:0]); end
    else if (a == 16'hFFFF) begin eReq = "R7"; eSel[9] = 1; end
    else begin eReq = "R7"; eSel[8] = 1; eOff = 15'(a[6:0]); end
    if (eBlk && !wr) eFill = 8'hFF;
  endfunction

  task automatic step(logic [15:0] a, logic rd, logic wr, logic [1:0] md, logic bl, logic [2:0] bv);
    @(negedge clk);
    chk("R10", "errPulse", 32'(errPulse), 32'(expErr));
    chk("R4", "wramBank", 32'(wramBank), 32'(expBank));
    busAddr = a; busRd = rd; busWr = wr; vidMode = md; bankLoad = bl; bankVal = bv;
    #1;
    model(a, rd, wr, md, expBank);
    chk(eReq, "tgtSel", 32'(tgtSel), 32'(eSel));
    chk(eReq, "tgtOffset", 32'(tgtOffset), 32'(eOff));
    chk("R8", "mbcWr", 32'(mbcWr), 32'(eMbc));
    chk("R9", "rdFill", 32'(rdFill), 32'(eFill));
    expErr = eBlk;
    if (bl) expBank = (bv == 0) ? 3'd1 : bv;
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    // Reset state: R4 bank 1, R10 no error, R11 idle selects nothing
    chk("R4", "reset wramBank", 32'(wramBank), 32'd1);
    chk("R10", "reset errPulse", 32'(errPulse), 32'd0);
    chk("R11", "reset tgtSel", 32'(tgtSel), 32'd0);
    rstN = 1'b1;
    // Directed corners
    step(16'h3FFF, 1, 0, 0, 0, 0);   // R1 fixed ROM top
    step(16'h4000, 1, 0, 0, 0, 0);   // R1 switchable ROM base
    step(16'h7FFF, 0, 1, 0, 0, 0);   // R8 command write
    step(16'h9FFF, 1, 0, 3, 0, 0);   // R1 video RAM
    step(16'hE123, 1, 0, 0, 0, 0);   // R2 mirror
    step(16'hD456, 1, 0, 0, 1, 3'd0);// R3 with R4 zero load -> 1
    step(16'hF456, 1, 0, 0, 1, 3'd5);// R3 mirror, bank 1 still
    step(16'hFDFF, 0, 1, 0, 0, 0);   // R3 mirror top, bank 5
    step(16'hFE9F, 1, 0, 1, 0, 0);   // R5 allowed
    step(16'hFE00, 1, 0, 2, 0, 0);   // R5 blocked read
    step(16'hFE10, 0, 1, 3, 0, 0);   // R5 blocked write, R10
    step(16'hFEA0, 1, 0, 0, 0, 0);   // R6
    step(16'hFF7F, 1, 0, 0, 0, 0);   // R7 I/O
    step(16'hFF80, 1, 0, 0, 0, 0);   // R7 high RAM
    step(16'hFFFE, 0, 1, 0, 0, 0);   // R7 high RAM top
    step(16'hFFFF, 1, 0, 0, 0, 0);   // R7 interrupt enable
    step(16'hFEFF, 0, 0, 3, 0, 0);   // R11 idle on unusable range
    step(16'h0000, 0, 0, 0, 0, 0);
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      logic [1:0]  acc;
      a = 16'($urandom);
      if ($urandom_range(0, 1) == 1) a[15:9] = 7'h7F;
      acc = 2'($urandom_range(0, 3));
      step(a, acc[0], acc[1], 2'($urandom), ($urandom_range(0, 7) == 0), 3'($urandom));
    end
    step(16'h0000, 0, 0, 0, 0, 0);
    done = 1'b1;
    finishRun();
  end
endmodule